// File: doc/BRIEF.md
# Streaming Fletcher-32 Checksum Engine

This block computes a 32-bit Fletcher checksum over a stream of 16-bit words. It keeps two running sums. The first sum, A, collects the data. The second sum, B, collects each new value of A. Both sums are kept as residues modulo 65535. Words enter through a valid/ready handshake, and a last flag marks the final word of a message. One cycle after the last word is accepted, the block presents the checksum as {B, A}. The result stays on the outputs until the next start pulse.

A start pulse clears both sums, any half-assembled word and the result, and so prepares the block for a new message. While the result is being presented, `in_ready` stays low, so back-pressure holds the next message until the host has read the checksum and issued start. `in_ready` is also low during the start cycle itself. A beat moves only in a cycle where `in_valid` and `in_ready` are both high.

In byte mode, each beat carries one octet on `in_data[7:0]` and the upper bits are ignored. Octets are paired into words with the earlier octet as the low byte. A message with an odd number of octets gets one zero octet as padding. `byte_mode` must be held constant from a start pulse until the result appears.

Top module: `fl32_engine`

## Requirements
- R1: For each accepted word D, A becomes A + D and then B becomes B + (new A), both modulo 65535. Idle cycles between beats do not change either sum.
- R2: `res_valid` rises in the cycle after the beat that carries `in_last` is accepted. At the same time `res_sum` shows B in bits 31:16 and A in bits 15:0.
- R3: A and B are always true residues in the range 0 to 65534. A word of 0xFFFF counts as zero, so a single 0xFFFF word gives a checksum of 0x00000000.
- R4: Messages of any length are summed correctly, with no limit on the number of words.
- R5: While `res_valid` is high and no start is asserted, `in_ready` is low, any offered beats are ignored, and `res_sum` holds steady.
- R6: A start pulse clears A, B, any pending octet and `res_valid`, and `in_ready` is low in that cycle. A message sent after a start depends only on its own data.
- R7: In byte mode, only `in_data[7:0]` is used. The first octet of each pair becomes bits 7:0 of the word and the second becomes bits 15:8, so "abcdef" gives 0x56502D2A.
- R8: In byte mode, an odd final octet is padded with a zero upper byte, so "abcde" gives 0xF04FC729.
- R9: After reset, `res_valid` is 0, `res_sum` is 0, `in_ready` is 1, and both sums start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the sums and the result so a new message can begin |
| byte_mode | input | 1 | 1: octets on bits 7:0 are packed into words; 0: full 16-bit words |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 16 | Data word, or an octet on bits 7:0 in byte mode |
| in_last | input | 1 | This beat ends the message |
| res_valid | output | 1 | Checksum is valid and held |
| res_sum | output | 32 | Checksum, {B, A} |

## Verification
The bench targets the modulo boundary: all-ones words must collapse to zero, and sums near 65535 must wrap correctly. A design that omits the final correction would show 0xFFFF in a field, and one that drops the end-around carry would be off by one. It checks the byte-pairing order and the odd-octet padding against the two known strings, which a swapped or unpadded packer fails. It also checks that a start in the middle of a message, including one that arrives while an octet is pending, leaves no trace in the next checksum, and that beats offered while the result is held cannot disturb it.

// File: rtl/fl32_pkg.sv
package fl32_pkg;
  localparam int FL_WORD_W = 16;
  localparam int FL_SUM_W  = 2 * FL_WORD_W;
endpackage

// File: rtl/fl32_modsum.sv
// Adds two values modulo (2^W - 1) by folding the end-around carry,
// then maps the all-ones code to zero so the output is a true residue.
module fl32_modsum #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W:0] wide;
  logic [W:0] fold;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    fold = {1'b0, wide[W-1:0]} + {{W{1'b0}}, wide[W]};
    if (fold[W])
      s = {{(W-1){1'b0}}, 1'b1};
    else if (&fold[W-1:0])
      s = '0;
    else
      s = fold[W-1:0];
  end
endmodule

// File: rtl/fl32_packer.sv
// Turns the input beats into words. In word mode each beat passes straight
// through. In byte mode octets are paired, earlier octet low, and an odd
// final octet is padded with a zero upper byte.
module fl32_packer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         byte_mode,
  input  logic         beat,
  input  logic [W-1:0] data,
  input  logic         last,
  output logic         word_vld,
  output logic [W-1:0] word,
  output logic         word_last
);
  localparam int H = W / 2;

  logic         hold_vld;
  logic [H-1:0] hold_byte;

  always_comb begin
    word_vld  = 1'b0;
    word      = data;
    word_last = last;
    if (!byte_mode) begin
      word_vld = beat;
    end else if (beat) begin
      if (hold_vld) begin
        word_vld = 1'b1;
        word     = {data[H-1:0], hold_byte};
      end else if (last) begin
        word_vld = 1'b1;
        word     = {{H{1'b0}}, data[H-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_byte <= '0;
    end else if (clr) begin
      hold_vld  <= 1'b0;
      hold_byte <= '0;
    end else if (byte_mode && beat) begin
      if (hold_vld) begin
        hold_vld <= 1'b0;
      end else if (!last) begin
        hold_vld  <= 1'b1;
        hold_byte <= data[H-1:0];
      end
    end
  end
endmodule

// File: rtl/fl32_accum.sv
// The two running sums. The next-state values are exported so the result
// can be captured in the same cycle as the last word.
module fl32_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] a_next,
  output logic [W-1:0] b_next
);
  logic [W-1:0] sum_a;
  logic [W-1:0] sum_b;

  fl32_modsum #(.W(W)) u_add_a (.a(sum_a), .b(d),      .s(a_next));
  fl32_modsum #(.W(W)) u_add_b (.a(sum_b), .b(a_next), .s(b_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_a <= '0;
      sum_b <= '0;
    end else if (clr) begin
      sum_a <= '0;
      sum_b <= '0;
    end else if (en) begin
      sum_a <= a_next;
      sum_b <= b_next;
    end
  end
endmodule

// File: rtl/fl32_engine.sv
module fl32_engine #(
  parameter int WORD_W = fl32_pkg::FL_WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                byte_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                in_last,
  output logic                res_valid,
  output logic [2*WORD_W-1:0] res_sum
);
  localparam int RES_W = 2 * WORD_W;

  logic              beat;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              word_last;
  logic [WORD_W-1:0] a_next;
  logic [WORD_W-1:0] b_next;
  logic              done_q;
  logic [RES_W-1:0]  sum_q;

  assign in_ready = !done_q && !start;
  assign beat     = in_valid && in_ready;

  fl32_packer #(.W(WORD_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .byte_mode(byte_mode),
    .beat     (beat),
    .data     (in_data),
    .last     (in_last),
    .word_vld (word_vld),
    .word     (word),
    .word_last(word_last)
  );

  fl32_accum #(.W(WORD_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .en    (word_vld),
    .d     (word),
    .a_next(a_next),
    .b_next(b_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      sum_q  <= '0;
    end else if (start) begin
      done_q <= 1'b0;
    end else if (word_vld && word_last) begin
      done_q <= 1'b1;
      sum_q  <= {b_next, a_next};
    end
  end

  assign res_valid = done_q;
  assign res_sum   = sum_q;
endmodule

// File: rtl/fl32_engine_chk.sv
module fl32_engine_chk #(
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_last,
  input logic                res_valid,
  input logic [2*WORD_W-1:0] res_sum
);
  assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !start) |=> (res_valid && $stable(res_sum)));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !res_valid);

  assert_ready_low_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);

  assert_valid_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !start) |=> res_valid);

  assert_rise_needs_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid && in_ready && in_last));

  assert_residue_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!(&res_sum[WORD_W-1:0]) && !(&res_sum[2*WORD_W-1:WORD_W])));
endmodule

bind fl32_engine fl32_engine_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .res_valid(res_valid),
  .res_sum  (res_sum)
);

// File: tb/tb_fl32_engine.sv
module tb_fl32_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        byte_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        res_valid;
  logic [31:0] res_sum;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fl32_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .res_valid(res_valid), .res_sum(res_sum)
  );

  localparam int NV = 6;
  localparam logic [15:0] TV_W [0:NV-1][0:3] = '{
    '{16'h6261, 16'h6463, 16'h0065, 16'h0000},
    '{16'h6261, 16'h6463, 16'h6665, 16'h0000},
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0001, 16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFE, 16'hFFFE, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'h0001, 16'hFFFF, 16'h0002}
  };
  localparam int TV_LEN [0:NV-1] = '{3, 3, 1, 1, 2, 4};
  // last entry: A = 0,1,1,3 ; B = 0,1,2,5
  localparam logic [31:0] TV_EXP [0:NV-1] = '{
    32'hF04FC729, 32'h56502D2A, 32'h00000000,
    32'h00010001, 32'hFFFCFFFD, 32'h00050003
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_start();
    in_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    check("R6 in_ready low during start", {31'd0, in_ready}, 32'd0);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic beat(input logic [15:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [31:0] exp);
    @(negedge clk);
    check(req, {31'd0, res_valid}, 32'd1);
    check(req, res_sum, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 res_valid after reset", {31'd0, res_valid}, 32'd0);
    check("R9 res_sum after reset", res_sum, 32'd0);
    check("R9 in_ready after reset", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    // R9: sums start at zero without any start pulse
    beat(16'h0001, 1'b1);
    expect_result("R9 first message from reset", 32'h00010001);

    // Table walk in word mode (R1 R2 R3)
    for (int v = 0; v < NV; v++) begin
      do_start();
      for (int i = 0; i < TV_LEN[v]; i++)
        beat(TV_W[v][i], i == TV_LEN[v] - 1);
      expect_result("R1 R2 R3 table vector", TV_EXP[v]);
    end

    // R1: idle gaps between beats
    do_start();
    beat(16'h6261, 1'b0); repeat (3) @(posedge clk); #1;
    beat(16'h6463, 1'b0); repeat (2) @(posedge clk); #1;
    beat(16'h6665, 1'b1);
    expect_result("R1 gaps between beats", 32'h56502D2A);

    // R5: offered beats ignored while result held
    in_valid = 1'b1; in_data = 16'h1234; in_last = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5 in_ready low while held", {31'd0, in_ready}, 32'd0);
    check("R5 result unchanged", res_sum, 32'h56502D2A);
    #1 in_valid = 1'b0; in_last = 1'b0;
    @(posedge clk); #1;

    // R6: start mid-message discards partial sums
    do_start();
    beat(16'h1111, 1'b0);
    beat(16'h2222, 1'b0);
    do_start();
    @(negedge clk);
    check("R6 start clears res_valid", {31'd0, res_valid}, 32'd0);
    @(posedge clk); #1;
    beat(16'h0001, 1'b1);
    expect_result("R6 message after mid start", 32'h00010001);

    // R4: long message, reference by true modulo
    begin
      int ra = 0, rb = 0;
      do_start();
      for (int i = 0; i < 1000; i++) begin
        logic [15:0] d = 16'hFFFE - 16'(i % 7);
        ra = (ra + int'(d)) % 65535;
        rb = (rb + ra) % 65535;
        beat(d, i == 999);
      end
      expect_result("R4 long message", {rb[15:0], ra[15:0]});
    end

    // Byte mode: R7 even length, upper bits are garbage
    byte_mode = 1'b1;
    do_start();
    beat(16'hAB61, 1'b0); beat(16'hCD62, 1'b0); beat(16'hEF63, 1'b0);
    beat(16'h1264, 1'b0); beat(16'h3465, 1'b0); beat(16'h5666, 1'b1);
    expect_result("R7 byte pairing abcdef", 32'h56502D2A);

    // R8: odd length padded
    do_start();
    beat(16'h0061, 1'b0); beat(16'h0062, 1'b0); beat(16'h0063, 1'b0);
    beat(16'h0064, 1'b0); beat(16'h0065, 1'b1);
    expect_result("R8 odd octet padding abcde", 32'hF04FC729);

    // R8: single octet
    do_start();
    beat(16'h7780, 1'b1);
    expect_result("R8 single octet", 32'h00800080);

    // R6: start clears a pending octet
    do_start();
    beat(16'h0055, 1'b0);
    do_start();
    beat(16'h0080, 1'b1);
    expect_result("R6 pending octet cleared", 32'h00800080);

    byte_mode = 1'b0;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule